// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Handshake

This block sits between the serial engine of an audio port and an external DMA controller. It holds two sample FIFOs. The transmit FIFO is filled by the DMA controller and drained by the serial engine. The receive FIFO is filled by the serial engine and drained by the DMA controller. Each FIFO reports full and empty flags, together with sticky overflow and underflow bits.

Each direction has its own DMA-active enable. It also has a single-word request/acknowledge pair. Transmit asks for a word while its FIFO has room. Receive asks for service while its FIFO holds data. Each acknowledge cycle moves exactly one word, and the FIFO access happens in that same cycle. The two directions share no state, so both requests may be high at the same time.

Top module: `afd_dma_fifo`

## Requirements
- R1: While reset is applied, both empty flags read 1. Both full flags read 0. Both requests and all four sticky bits read 0.
- R2: After every clock edge, tx_dreq equals the tx_dma_en value sampled at that edge, ANDed with "the transmit FIFO holds fewer than DEPTH (16) words after that edge's update".
- R3: After every clock edge, rx_dreq equals the rx_dma_en value sampled at that edge, ANDed with "the receive FIFO holds at least one word after that edge's update".
- R4: A cycle with tx_dack high writes tx_dwdata into the transmit FIFO, one word per cycle. A cycle with rx_dack high removes one word from the receive FIFO. While rx_dack is high, rx_drdata shows the word being removed.
- R5: When an acknowledged word makes the transmit FIFO full, tx_dreq is low in the next cycle. When an acknowledged word makes the receive FIFO empty, rx_dreq is low in the next cycle.
- R6: tx_full and rx_full read 1 exactly when their FIFO holds 16 words. tx_empty and rx_empty read 1 exactly when their FIFO holds none.
- R7: A write into a full FIFO or a read from an empty FIFO leaves the FIFO unchanged. This holds even when the opposite operation happens in the same cycle. Such an access sets that FIFO's overflow or underflow bit, which stays set until reset.
- R8: A low DMA enable at a clock edge makes that request low in the next cycle. The FIFO contents are left as they were.
- R9: The transmit and receive sides work independently, and both requests may be high in the same cycle.
- R10: Words leave each FIFO in the order they entered. eng_tx_data always shows the oldest word in the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_dma_en | input | 1 | Transmit DMA-active enable |
| rx_dma_en | input | 1 | Receive DMA-active enable |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_dack | input | 1 | Transmit DMA acknowledge; write strobe for the transmit FIFO |
| tx_dwdata | input | 32 | Word written by the DMA controller |
| rx_dreq | output | 1 | Receive DMA request |
| rx_dack | input | 1 | Receive DMA acknowledge; read strobe for the receive FIFO |
| rx_drdata | output | 32 | Oldest receive word, read by the DMA controller |
| eng_tx_pop | input | 1 | Serial engine takes one transmit word |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_rx_push | input | 1 | Serial engine stores one receive word |
| eng_rx_data | input | 32 | Word stored by the serial engine |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| tx_ovf | output | 1 | Sticky: write into a full transmit FIFO |
| tx_unf | output | 1 | Sticky: read from an empty transmit FIFO |
| rx_ovf | output | 1 | Sticky: write into a full receive FIFO |
| rx_unf | output | 1 | Sticky: read from an empty receive FIFO |

## Verification
Flags, sticky bits and requests are registered, so each one is due in the cycle after the edge that sampled the stimulus. The data outputs show the FIFO head through combinational logic, so they are valid in that same post-edge cycle. The bench drives inputs on the falling edge and lets one rising edge update its reference model. On the following falling edge it compares every output, which keeps each comparison exactly one edge after its cause. After each reset release the bench holds three idle cycles, because the internal reset is released through two synchronizer stages.

// File: rtl/afd_pkg.sv
package afd_pkg;
  typedef struct packed {
    logic full;
    logic empty;
    logic ovf;
    logic unf;
  } afd_stat_t;
endpackage

// File: rtl/afd_rst_sync.sv
module afd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/afd_fifo.sv
module afd_fifo
  import afd_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output afd_stat_t     stat,
  output logic [CW-1:0] cnt_nxt
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic          ovf_q, unf_q, ovf_d, unf_d;
  logic          full, empty, do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wp_d    = wp_q;
    rp_d    = rp_q;
    cnt_nxt = cnt_q;
    if (do_push) begin
      wp_d    = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      cnt_nxt = cnt_nxt + 1'b1;
    end
    if (do_pop) begin
      rp_d    = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_nxt = cnt_nxt - 1'b1;
    end
    ovf_d = ovf_q | (push && full);
    unf_d = unf_q | (pop && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  assign head       = mem[rp_q];
  assign stat.full  = full;
  assign stat.empty = empty;
  assign stat.ovf   = ovf_q;
  assign stat.unf   = unf_q;
endmodule

// File: rtl/afd_req_gate.sv
module afd_req_gate #(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt_nxt,
  output logic          req
);
  logic ready, req_d, req_q;

  generate
    if (IS_TX) begin : g_room
      assign ready = (cnt_nxt != CW'(DEPTH));
    end else begin : g_data
      assign ready = (cnt_nxt != '0);
    end
  endgenerate

  always_comb req_d = en && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/afd_dma_fifo.sv
module afd_dma_fifo
  import afd_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_dma_en,
  input  logic         rx_dma_en,
  output logic         tx_dreq,
  input  logic         tx_dack,
  input  logic [W-1:0] tx_dwdata,
  output logic         rx_dreq,
  input  logic         rx_dack,
  output logic [W-1:0] rx_drdata,
  input  logic         eng_tx_pop,
  output logic [W-1:0] eng_tx_data,
  input  logic         eng_rx_push,
  input  logic [W-1:0] eng_rx_data,
  output logic         tx_empty,
  output logic         tx_full,
  output logic         rx_empty,
  output logic         rx_full,
  output logic         tx_ovf,
  output logic         tx_unf,
  output logic         rx_ovf,
  output logic         rx_unf
);
  logic          rst_n_i;
  afd_stat_t     tx_st, rx_st;
  logic [CW-1:0] tx_cnt_nxt, rx_cnt_nxt;

  afd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  afd_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n_i),
    .push(tx_dack), .push_data(tx_dwdata), .pop(eng_tx_pop),
    .head(eng_tx_data), .stat(tx_st), .cnt_nxt(tx_cnt_nxt)
  );

  afd_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n_i),
    .push(eng_rx_push), .push_data(eng_rx_data), .pop(rx_dack),
    .head(rx_drdata), .stat(rx_st), .cnt_nxt(rx_cnt_nxt)
  );

  afd_req_gate #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_req (
    .clk(clk), .rst_n(rst_n_i), .en(tx_dma_en), .cnt_nxt(tx_cnt_nxt), .req(tx_dreq)
  );

  afd_req_gate #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_req (
    .clk(clk), .rst_n(rst_n_i), .en(rx_dma_en), .cnt_nxt(rx_cnt_nxt), .req(rx_dreq)
  );

  assign tx_empty = tx_st.empty;
  assign tx_full  = tx_st.full;
  assign tx_ovf   = tx_st.ovf;
  assign tx_unf   = tx_st.unf;
  assign rx_empty = rx_st.empty;
  assign rx_full  = rx_st.full;
  assign rx_ovf   = rx_st.ovf;
  assign rx_unf   = rx_st.unf;
endmodule

// File: rtl/afd_dma_fifo_chk.sv
module afd_dma_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_dma_en,
  input logic rx_dma_en,
  input logic tx_dreq,
  input logic rx_dreq,
  input logic tx_dack,
  input logic rx_dack,
  input logic eng_tx_pop,
  input logic eng_rx_push,
  input logic tx_empty,
  input logic tx_full,
  input logic rx_empty,
  input logic rx_full,
  input logic tx_ovf,
  input logic tx_unf,
  input logic rx_ovf,
  input logic rx_unf
);
  a_r2_tx_req_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> !tx_full);
  a_r3_rx_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq |-> !rx_empty);
  a_r8_tx_en_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dma_en |=> !tx_dreq);
  a_r8_rx_en_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dma_en |=> !rx_dreq);
  a_r6_tx_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));
  a_r6_rx_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty));
  a_r7_tx_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dack && tx_full) |=> tx_ovf);
  a_r7_rx_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dack && rx_empty) |=> rx_unf);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf || rx_ovf) |=> ($past(tx_ovf) -> tx_ovf) && ($past(rx_ovf) -> rx_ovf));
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dack && tx_full && !eng_tx_pop) |=> tx_full);
  a_r5_rx_empty_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dack && !eng_rx_push && rx_dreq) |=> (rx_empty -> !rx_dreq));
endmodule

bind afd_dma_fifo afd_dma_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
  .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .tx_dack(tx_dack), .rx_dack(rx_dack),
  .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
  .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
  .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
);

// File: tb/afd_dma_fifo_bench.sv
module afd_dma_fifo_bench;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_dma_en, rx_dma_en, tx_dack, rx_dack, eng_tx_pop, eng_rx_push;
  logic [31:0] tx_dwdata, eng_rx_data, rx_drdata, eng_tx_data;
  logic        tx_dreq, rx_dreq, tx_empty, tx_full, rx_empty, rx_full;
  logic        tx_ovf, tx_unf, rx_ovf, rx_unf;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [31:0] tq[$];
  logic [31:0] rq[$];
  logic e_treq, e_rreq, e_tovf, e_tunf, e_rovf, e_runf;

  always #5 clk = ~clk;

  afd_dma_fifo u_afd_dma_fifo (
    .clk(clk), .rst_n(rst_n), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_dreq(tx_dreq), .tx_dack(tx_dack), .tx_dwdata(tx_dwdata),
    .rx_dreq(rx_dreq), .rx_dack(rx_dack), .rx_drdata(rx_drdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
    .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    chk("R6 tx_empty", 32'(tx_empty), 32'(tq.size() == 0));
    chk("R6 tx_full",  32'(tx_full),  32'(tq.size() == D));
    chk("R6 rx_empty", 32'(rx_empty), 32'(rq.size() == 0));
    chk("R6 rx_full",  32'(rx_full),  32'(rq.size() == D));
    chk("R2 R5 R8 tx_dreq", 32'(tx_dreq), 32'(e_treq));
    chk("R3 R5 R9 rx_dreq", 32'(rx_dreq), 32'(e_rreq));
    chk("R7 tx_ovf", 32'(tx_ovf), 32'(e_tovf));
    chk("R7 tx_unf", 32'(tx_unf), 32'(e_tunf));
    chk("R7 rx_ovf", 32'(rx_ovf), 32'(e_rovf));
    chk("R7 rx_unf", 32'(rx_unf), 32'(e_runf));
    if (tq.size() > 0) chk("R10 eng_tx_data", eng_tx_data, tq[0]);
    if (rq.size() > 0) chk("R4 R10 rx_drdata", rx_drdata, rq[0]);
  endtask

  function automatic logic pick(int pct);
    return (($urandom % 100) < pct);
  endfunction

  // one cycle per iteration: check state, drive at negedge, model the rising edge
  task automatic phase(int n, int p_ten, int p_tack, int p_pop, int p_ren, int p_push, int p_rack);
    for (int i = 0; i < n; i++) begin
      check_all();
      tx_dma_en   = pick(p_ten);
      tx_dack     = pick(p_tack);
      eng_tx_pop  = pick(p_pop);
      rx_dma_en   = pick(p_ren);
      eng_rx_push = pick(p_push);
      rx_dack     = pick(p_rack);
      tx_dwdata   = $urandom;
      eng_rx_data = $urandom;
      @(posedge clk);
      // transmit side: full/empty judged on the pre-edge count (R7)
      if (tx_dack && tq.size() == D) e_tovf = 1'b1;
      if (eng_tx_pop && tq.size() == 0) e_tunf = 1'b1;
      begin
        logic tpush, tpop;
        tpush = tx_dack && tq.size() < D;
        tpop  = eng_tx_pop && tq.size() > 0;
        if (tpop)  void'(tq.pop_front());
        if (tpush) tq.push_back(tx_dwdata);
      end
      if (eng_rx_push && rq.size() == D) e_rovf = 1'b1;
      if (rx_dack && rq.size() == 0) e_runf = 1'b1;
      begin
        logic rpush, rpop;
        rpush = eng_rx_push && rq.size() < D;
        rpop  = rx_dack && rq.size() > 0;
        if (rpop)  void'(rq.pop_front());
        if (rpush) rq.push_back(eng_rx_data);
      end
      e_treq = tx_dma_en && (tq.size() < D);
      e_rreq = rx_dma_en && (rq.size() > 0);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tx_dma_en = 0; rx_dma_en = 0; tx_dack = 0; rx_dack = 0;
    eng_tx_pop = 0; eng_rx_push = 0; tx_dwdata = 0; eng_rx_data = 0;
    tq.delete(); rq.delete();
    e_treq = 0; e_rreq = 0; e_tovf = 0; e_tunf = 0; e_rovf = 0; e_runf = 0;
    @(negedge clk);
    chk("R1 tx_empty", 32'(tx_empty), 32'd1);
    chk("R1 rx_empty", 32'(rx_empty), 32'd1);
    chk("R1 tx_full",  32'(tx_full),  32'd0);
    chk("R1 rx_full",  32'(rx_full),  32'd0);
    chk("R1 requests", 32'({tx_dreq, rx_dreq}), 32'd0);
    chk("R1 sticky",   32'({tx_ovf, tx_unf, rx_ovf, rx_unf}), 32'd0);
    rst_n = 1'b1;
    phase(3, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_a11d));
    rst_n = 1'b0;
    do_reset();
    // R4 R5 R7: fill transmit to full and beyond
    phase(20, 100, 100, 0, 0, 0, 0);
    // R8: enable cleared, contents must survive
    phase(4, 0, 0, 0, 0, 0, 0);
    // R7 R10: drain transmit past empty
    phase(20, 100, 0, 100, 0, 0, 0);
    // R3 R7: fill receive past full
    phase(20, 0, 0, 0, 100, 100, 0);
    // R4 R5 R7 R9: drain receive past empty while transmit also runs
    phase(20, 100, 40, 30, 100, 0, 100);
    do_reset();
    // R9: both directions active at once
    phase(30, 100, 60, 30, 100, 60, 30);
    phase(3000, 80, 50, 40, 80, 40, 50);
    phase(2000, 90, 70, 20, 90, 20, 70);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule